// File: doc/BRIEF.md
# Recursive NaN-Box and Sign-Injection Unit

This block sits between a 128-bit floating-point register file and the arithmetic datapath. One register can hold a quad-precision value that fills all of it, a double-precision value, or a single-precision value. A narrower value is NaN-boxed by filling the unused upper bits with ones. The boxing is recursive: a single-precision value is boxed inside a double-precision container, and that container is boxed inside the 128-bit register.

On the write side, the unit boxes a datapath result, a memory load or its own sign-injection result to the selected format. It then presents a write value and a write enable. On the read side, it unboxes two source operands. A narrow operand whose boxing is broken at either level is replaced by the canonical quiet NaN of its format, and a flag is raised. The unit also performs copy-sign, copy-negated-sign and XOR-sign at single, double or quad precision. The half-precision format code is recognised but rejected.

The core is combinational. A parameter adds one register stage on every output.

Top module: `fpr_box_unit`

## Requirements
- R1: The format code `fmt_i` is decoded as 00 = single (32-bit), 01 = double (64-bit), 10 = half, 11 = quad (128-bit). Code 10 raises `illegal_o`, drops `wr_en_o` and drives `wr_val_o` to zero, so the register keeps its contents. In this case both unboxed operands read as zero with no box error.
- R2: With `op_i` = 00 (datapath result, from `res_i`) or 01 (load, from `load_i`) at single format, `wr_val_o` is bits [127:32] all ones above the source's bits [31:0], and `wr_en_o` is 1.
- R3: With `op_i` = 00 or 01 at double format, `wr_val_o` is bits [127:64] all ones above the source's bits [63:0].
- R4: With `op_i` = 00 or 01 at quad format, all 128 source bits reach `wr_val_o` unmodified, including the payloads of non-canonical NaNs.
- R5: A single operand is valid only when bits [127:64] are all ones and bits [63:32] are all ones. If valid, the unboxed output is bits [31:0] zero-extended. Otherwise the output is 0x7FC00000 zero-extended and the operand's box-error flag is set.
- R6: A double operand is valid only when bits [127:64] are all ones. If valid, the unboxed output is bits [63:0] zero-extended. Otherwise the output is 0x7FF8000000000000 zero-extended and the box-error flag is set.
- R7: At quad format each operand passes to its unboxed output unchanged, and its box-error flag is 0.
- R8: With `op_i` = 10 (sign injection), `sub_i` selects the new sign: 000 takes the sign of operand 2, 001 takes its inverse, and 010 takes the XOR of both signs. Any other `sub_i` value raises `illegal_o` and drops `wr_en_o`.
- R9: At single or double format, sign injection works on the unboxed operands, so a badly boxed input contributes its canonical NaN. The result is boxed again as in R2/R3.
- R10: At quad format, sign injection keeps bits [126:0] of operand 1 unchanged and writes only bit 127.
- R11: `op_i` = 11 is reserved. It raises `illegal_o` and drops `wr_en_o`, while the unboxed operand outputs still follow R5–R7.
- R12: With `OUT_REG` = 1, every output reflects the inputs one clock earlier. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| fmt_i | input | 2 | Format code |
| op_i | input | 2 | Operation select: result, load, sign injection, reserved |
| sub_i | input | 3 | Sign-injection variant |
| rs1_i | input | FLEN | Source operand 1 as held in the register |
| rs2_i | input | FLEN | Source operand 2 as held in the register |
| res_i | input | FLEN | Datapath result, narrow values in the low bits |
| load_i | input | FLEN | Memory load data, narrow values in the low bits |
| wr_en_o | output | 1 | Register write enable |
| wr_val_o | output | FLEN | Boxed register write value |
| opa_o | output | FLEN | Unboxed operand 1, zero-extended |
| opb_o | output | FLEN | Unboxed operand 2, zero-extended |
| opa_boxerr_o | output | 1 | Operand 1 was replaced by a canonical NaN |
| opb_boxerr_o | output | 1 | Operand 2 was replaced by a canonical NaN |
| illegal_o | output | 1 | Unsupported format, reserved operation or bad variant |

## Verification
The bench builds two copies with the default widths (128/64/32): one with `OUT_REG` = 1 and one with `OUT_REG` = 0. Both are compared against one behavioural model, so a single stimulus stream checks both the combinational path and the registered timing and reset clearing.

With the default widths, the bench can set exact corruption points: an upper half that is intact with a broken [63:32] word, a single cleared bit at 127, and quad NaN payloads with arbitrary bits. These separate the two levels of the recursive box check from each other and from the quad pass-through.

// File: rtl/fpr_box_pkg.sv
package fpr_box_pkg;

   localparam logic [1:0] FMT_SGL  = 2'b00;
   localparam logic [1:0] FMT_DBL  = 2'b01;
   localparam logic [1:0] FMT_HALF = 2'b10;
   localparam logic [1:0] FMT_QUAD = 2'b11;

   localparam logic [1:0] OP_RES  = 2'b00;
   localparam logic [1:0] OP_LOAD = 2'b01;
   localparam logic [1:0] OP_SGNJ = 2'b10;
   localparam logic [1:0] OP_RSVD = 2'b11;

   localparam logic [2:0] SJ_COPY = 3'b000;
   localparam logic [2:0] SJ_NEG  = 3'b001;
   localparam logic [2:0] SJ_XOR  = 3'b010;

   localparam int NUM_SRC  = 2;
   localparam int NUM_PREC = 3;

   typedef struct packed {
      logic wr_en;
      logic illegal;
      logic aerr;
      logic berr;
   } box_flags_t;

endpackage

// File: rtl/fpr_unbox.sv
module fpr_unbox
   import fpr_box_pkg::*;
#(
   parameter int FLEN = 128,
   parameter int DLEN = 64,
   parameter int SLEN = 32,
   parameter int SEXP = 8,
   parameter int DEXP = 11
) (
   input  logic [1:0]      fmt_i,
   input  logic [FLEN-1:0] val_i,
   output logic [FLEN-1:0] op_o,
   output logic            boxerr_o
);
   localparam logic [SLEN-1:0] S_QNAN = {1'b0, {SEXP{1'b1}}, 1'b1, {(SLEN-SEXP-2){1'b0}}};
   localparam logic [DLEN-1:0] D_QNAN = {1'b0, {DEXP{1'b1}}, 1'b1, {(DLEN-DEXP-2){1'b0}}};

   logic            outer_ok;
   logic            inner_ok;
   logic [DLEN-1:0] dbl_view;
   logic [SLEN-1:0] sgl_view;

   // level 1: the double container inside the register
   assign outer_ok = &val_i[FLEN-1:DLEN];
   assign dbl_view = outer_ok ? val_i[DLEN-1:0] : D_QNAN;
   // level 2: the single inside the (possibly substituted) double
   assign inner_ok = &dbl_view[DLEN-1:SLEN];
   assign sgl_view = inner_ok ? dbl_view[SLEN-1:0] : S_QNAN;

   always_comb begin
      op_o     = '0;
      boxerr_o = 1'b0;
      case (fmt_i)
         FMT_SGL: begin
            op_o     = {{(FLEN-SLEN){1'b0}}, sgl_view};
            boxerr_o = ~inner_ok;
         end
         FMT_DBL: begin
            op_o     = {{(FLEN-DLEN){1'b0}}, dbl_view};
            boxerr_o = ~outer_ok;
         end
         FMT_QUAD: op_o = val_i;
         default:  op_o = '0;
      endcase
   end
endmodule

// File: rtl/fpr_sgnj.sv
module fpr_sgnj
   import fpr_box_pkg::*;
#(
   parameter int FLEN = 128,
   parameter int DLEN = 64,
   parameter int SLEN = 32
) (
   input  logic [1:0]      fmt_i,
   input  logic [2:0]      sub_i,
   input  logic [FLEN-1:0] a_i,
   input  logic [FLEN-1:0] b_i,
   output logic [FLEN-1:0] res_o,
   output logic            badsub_o
);
   logic [FLEN-1:0] cand [NUM_PREC];

   for (genvar k = 0; k < NUM_PREC; k++) begin : g_prec
      localparam int SB = (k == 0) ? SLEN-1 : (k == 1) ? DLEN-1 : FLEN-1;
      localparam logic [FLEN-1:0] MASK = {{(FLEN-1){1'b0}}, 1'b1} << SB;
      logic new_sign;
      always_comb begin
         case (sub_i)
            SJ_NEG:  new_sign = ~b_i[SB];
            SJ_XOR:  new_sign = a_i[SB] ^ b_i[SB];
            default: new_sign = b_i[SB];
         endcase
      end
      assign cand[k] = (a_i & ~MASK) | (new_sign ? MASK : '0);
   end

   always_comb begin
      case (fmt_i)
         FMT_SGL: res_o = cand[0];
         FMT_DBL: res_o = cand[1];
         default: res_o = cand[2];
      endcase
   end

   assign badsub_o = (sub_i != SJ_COPY) && (sub_i != SJ_NEG) && (sub_i != SJ_XOR);
endmodule

// File: rtl/fpr_rebox.sv
module fpr_rebox
   import fpr_box_pkg::*;
#(
   parameter int FLEN = 128,
   parameter int DLEN = 64,
   parameter int SLEN = 32
) (
   input  logic [1:0]      fmt_i,
   input  logic [FLEN-1:0] val_i,
   output logic [FLEN-1:0] box_o
);
   logic [DLEN-1:0] inner_box;

   // single boxed into a double first, then the double into the register
   assign inner_box = {{(DLEN-SLEN){1'b1}}, val_i[SLEN-1:0]};

   always_comb begin
      case (fmt_i)
         FMT_SGL: box_o = {{(FLEN-DLEN){1'b1}}, inner_box};
         FMT_DBL: box_o = {{(FLEN-DLEN){1'b1}}, val_i[DLEN-1:0]};
         default: box_o = val_i;
      endcase
   end
endmodule

// File: rtl/fpr_box_unit.sv
module fpr_box_unit
   import fpr_box_pkg::*;
#(
   parameter int FLEN    = 128,
   parameter int DLEN    = 64,
   parameter int SLEN    = 32,
   parameter int SEXP    = 8,
   parameter int DEXP    = 11,
   parameter bit OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      fmt_i,
   input  logic [1:0]      op_i,
   input  logic [2:0]      sub_i,
   input  logic [FLEN-1:0] rs1_i,
   input  logic [FLEN-1:0] rs2_i,
   input  logic [FLEN-1:0] res_i,
   input  logic [FLEN-1:0] load_i,
   output logic            wr_en_o,
   output logic [FLEN-1:0] wr_val_o,
   output logic [FLEN-1:0] opa_o,
   output logic [FLEN-1:0] opb_o,
   output logic            opa_boxerr_o,
   output logic            opb_boxerr_o,
   output logic            illegal_o
);
   if (!(SLEN < DLEN && DLEN < FLEN)) begin : g_bad_widths
      $error("fpr_box_unit: widths must nest SLEN < DLEN < FLEN");
   end
   if (SEXP + 2 >= SLEN || DEXP + 2 >= DLEN) begin : g_bad_exp
      $error("fpr_box_unit: exponent width leaves no mantissa");
   end

   logic [FLEN-1:0] src   [NUM_SRC];
   logic [FLEN-1:0] unbx  [NUM_SRC];
   logic            berr  [NUM_SRC];

   assign src[0] = rs1_i;
   assign src[1] = rs2_i;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      fpr_unbox #(.FLEN(FLEN), .DLEN(DLEN), .SLEN(SLEN), .SEXP(SEXP), .DEXP(DEXP)) u_unbox (
         .fmt_i    (fmt_i),
         .val_i    (src[i]),
         .op_o     (unbx[i]),
         .boxerr_o (berr[i])
      );
   end

   logic [FLEN-1:0] sj_res;
   logic            sj_badsub;

   fpr_sgnj #(.FLEN(FLEN), .DLEN(DLEN), .SLEN(SLEN)) u_sgnj (
      .fmt_i    (fmt_i),
      .sub_i    (sub_i),
      .a_i      (unbx[0]),
      .b_i      (unbx[1]),
      .res_o    (sj_res),
      .badsub_o (sj_badsub)
   );

   logic [FLEN-1:0] wsrc;
   always_comb begin
      case (op_i)
         OP_LOAD: wsrc = load_i;
         OP_SGNJ: wsrc = sj_res;
         default: wsrc = res_i;
      endcase
   end

   logic [FLEN-1:0] boxed;
   fpr_rebox #(.FLEN(FLEN), .DLEN(DLEN), .SLEN(SLEN)) u_rebox (
      .fmt_i (fmt_i),
      .val_i (wsrc),
      .box_o (boxed)
   );

   logic            illegal_c;
   box_flags_t      flags_c;
   logic [FLEN-1:0] wval_c;

   assign illegal_c = (fmt_i == FMT_HALF) || (op_i == OP_RSVD)
                    || ((op_i == OP_SGNJ) && sj_badsub);
   assign wval_c    = illegal_c ? '0 : boxed;
   assign flags_c   = '{wr_en: ~illegal_c, illegal: illegal_c, aerr: berr[0], berr: berr[1]};

   box_flags_t      flags_q;
   logic [FLEN-1:0] wval_q;
   logic [FLEN-1:0] opa_q;
   logic [FLEN-1:0] opb_q;

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q <= '0;
            wval_q  <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
         end else begin
            flags_q <= flags_c;
            wval_q  <= wval_c;
            opa_q   <= unbx[0];
            opb_q   <= unbx[1];
         end
      end
   end else begin : g_comb
      assign flags_q = flags_c;
      assign wval_q  = wval_c;
      assign opa_q   = unbx[0];
      assign opb_q   = unbx[1];
   end

   assign wr_en_o      = flags_q.wr_en;
   assign illegal_o    = flags_q.illegal;
   assign opa_boxerr_o = flags_q.aerr;
   assign opb_boxerr_o = flags_q.berr;
   assign wr_val_o     = wval_q;
   assign opa_o        = opa_q;
   assign opb_o        = opb_q;
endmodule

// File: rtl/fpr_box_unit_chk.sv
module fpr_box_unit_chk
   import fpr_box_pkg::*;
#(
   parameter int FLEN    = 128,
   parameter int DLEN    = 64,
   parameter int SLEN    = 32,
   parameter int SEXP    = 8,
   parameter int DEXP    = 11,
   parameter bit OUT_REG = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      fmt_i,
   input logic [1:0]      op_i,
   input logic [FLEN-1:0] rs1_i,
   input logic [FLEN-1:0] load_i,
   input logic            wr_en_o,
   input logic [FLEN-1:0] wr_val_o,
   input logic [FLEN-1:0] opa_o,
   input logic            opa_boxerr_o,
   input logic            illegal_o
);
   localparam logic [SLEN-1:0] S_QNAN = {1'b0, {SEXP{1'b1}}, 1'b1, {(SLEN-SEXP-2){1'b0}}};
   localparam logic [DLEN-1:0] D_QNAN = {1'b0, {DEXP{1'b1}}, 1'b1, {(DLEN-DEXP-2){1'b0}}};

   logic [1:0]      fmt_d;
   logic [1:0]      op_d;
   logic [FLEN-1:0] rs1_d;
   logic [FLEN-1:0] load_d;
   logic            primed;

   if (OUT_REG) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fmt_d  <= '0;
            op_d   <= '0;
            rs1_d  <= '0;
            load_d <= '0;
            primed <= 1'b0;
         end else begin
            fmt_d  <= fmt_i;
            op_d   <= op_i;
            rs1_d  <= rs1_i;
            load_d <= load_i;
            primed <= 1'b1;
         end
      end
   end else begin : g_direct
      assign fmt_d  = fmt_i;
      assign op_d   = op_i;
      assign rs1_d  = rs1_i;
      assign load_d = load_i;
      assign primed = rst_n;
   end

   assert_half_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && fmt_d == FMT_HALF) |-> (illegal_o && !wr_en_o && wr_val_o == '0));

   assert_single_box_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && wr_en_o && fmt_d == FMT_SGL) |-> (&wr_val_o[FLEN-1:SLEN]));

   assert_double_box_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && wr_en_o && fmt_d == FMT_DBL) |-> (&wr_val_o[FLEN-1:DLEN]));

   assert_quad_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && op_d == OP_LOAD && fmt_d == FMT_QUAD) |-> (wr_val_o == load_d));

   assert_single_unbox_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && fmt_d == FMT_SGL && (&rs1_d[FLEN-1:SLEN]))
      |-> (!opa_boxerr_o && opa_o == {{(FLEN-SLEN){1'b0}}, rs1_d[SLEN-1:0]}));

   assert_canon_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && opa_boxerr_o)
      |-> ((fmt_d == FMT_SGL && opa_o == {{(FLEN-SLEN){1'b0}}, S_QNAN})
        || (fmt_d == FMT_DBL && opa_o == {{(FLEN-DLEN){1'b0}}, D_QNAN})));

   assert_quad_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && fmt_d == FMT_QUAD) |-> (opa_o == rs1_d && !opa_boxerr_o));

   assert_quad_sgnj_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && wr_en_o && op_d == OP_SGNJ && fmt_d == FMT_QUAD)
      |-> (wr_val_o[FLEN-2:0] == rs1_d[FLEN-2:0]));

   assert_rsvd_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && op_d == OP_RSVD) |-> (illegal_o && !wr_en_o));
endmodule

bind fpr_box_unit fpr_box_unit_chk #(
   .FLEN(FLEN), .DLEN(DLEN), .SLEN(SLEN), .SEXP(SEXP), .DEXP(DEXP), .OUT_REG(OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fmt_i        (fmt_i),
   .op_i         (op_i),
   .rs1_i        (rs1_i),
   .load_i       (load_i),
   .wr_en_o      (wr_en_o),
   .wr_val_o     (wr_val_o),
   .opa_o        (opa_o),
   .opa_boxerr_o (opa_boxerr_o),
   .illegal_o    (illegal_o)
);

// File: tb/sim_fpr_box_unit.sv
module sim_fpr_box_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   fmt = 2'b00;
   logic [1:0]   op = 2'b00;
   logic [2:0]   sub = 3'b000;
   logic [127:0] rs1 = '0, rs2 = '0, res = '0, load = '0;

   logic         r_we, c_we, r_ill, c_ill, r_ae, c_ae, r_be, c_be;
   logic [127:0] r_wv, c_wv, r_oa, c_oa, r_ob, c_ob;

   logic         e_we, e_ill, e_ae, e_be;
   logic [127:0] e_wv, e_oa, e_ob;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fpr_box_unit #(.OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .op_i(op), .sub_i(sub),
      .rs1_i(rs1), .rs2_i(rs2), .res_i(res), .load_i(load),
      .wr_en_o(r_we), .wr_val_o(r_wv), .opa_o(r_oa), .opb_o(r_ob),
      .opa_boxerr_o(r_ae), .opb_boxerr_o(r_be), .illegal_o(r_ill));

   fpr_box_unit #(.OUT_REG(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .op_i(op), .sub_i(sub),
      .rs1_i(rs1), .rs2_i(rs2), .res_i(res), .load_i(load),
      .wr_en_o(c_we), .wr_val_o(c_wv), .opa_o(c_oa), .opb_o(c_ob),
      .opa_boxerr_o(c_ae), .opb_boxerr_o(c_be), .illegal_o(c_ill));

   task automatic chk(input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // behavioural model: bit loops over the register
   task automatic model_unbox(input logic [1:0] f, input logic [127:0] v,
                              output logic [127:0] o, output logic e);
      bit ok = 1'b1;
      o = '0;
      e = 1'b0;
      if (f == 2'b00) begin
         for (int i = 32; i < 128; i++) if (!v[i]) ok = 1'b0;
         o = ok ? {96'd0, v[31:0]} : 128'h7FC00000;
         e = !ok;
      end else if (f == 2'b01) begin
         for (int i = 64; i < 128; i++) if (!v[i]) ok = 1'b0;
         o = ok ? {64'd0, v[63:0]} : 128'h7FF8000000000000;
         e = !ok;
      end else if (f == 2'b11) begin
         o = v;
      end
   endtask

   task automatic model;
      logic [127:0] t;
      int  sb;
      logic ns;
      model_unbox(fmt, rs1, e_oa, e_ae);
      model_unbox(fmt, rs2, e_ob, e_be);
      e_ill = (fmt == 2'b10) || (op == 2'b11) || (op == 2'b10 && sub > 3'd2);
      e_we  = !e_ill;
      sb = (fmt == 2'b00) ? 31 : (fmt == 2'b01) ? 63 : 127;
      if (op == 2'b00) t = res;
      else if (op == 2'b01) t = load;
      else begin
         t = e_oa;
         if (sub == 3'd0) ns = e_ob[sb];
         else if (sub == 3'd1) ns = !e_ob[sb];
         else ns = e_oa[sb] ^ e_ob[sb];
         t[sb] = ns;
      end
      if (fmt == 2'b00) for (int i = 32; i < 128; i++) t[i] = 1'b1;
      if (fmt == 2'b01) for (int i = 64; i < 128; i++) t[i] = 1'b1;
      e_wv = e_ill ? '0 : t;
   endtask

   task automatic cmp(input string tag, input bit regd);
      if (regd) begin
         chk(tag, "u0.wr_en",   {127'd0, r_we},  {127'd0, e_we});
         chk(tag, "u0.wr_val",  r_wv, e_wv);
         chk(tag, "u0.opa",     r_oa, e_oa);
         chk(tag, "u0.opb",     r_ob, e_ob);
         chk(tag, "u0.aerr",    {127'd0, r_ae},  {127'd0, e_ae});
         chk(tag, "u0.berr",    {127'd0, r_be},  {127'd0, e_be});
         chk(tag, "u0.illegal", {127'd0, r_ill}, {127'd0, e_ill});
      end else begin
         chk(tag, "u1.wr_en",   {127'd0, c_we},  {127'd0, e_we});
         chk(tag, "u1.wr_val",  c_wv, e_wv);
         chk(tag, "u1.opa",     c_oa, e_oa);
         chk(tag, "u1.opb",     c_ob, e_ob);
         chk(tag, "u1.aerr",    {127'd0, c_ae},  {127'd0, e_ae});
         chk(tag, "u1.berr",    {127'd0, c_be},  {127'd0, e_be});
         chk(tag, "u1.illegal", {127'd0, c_ill}, {127'd0, e_ill});
      end
   endtask

   task automatic apply(input string tag, input logic [1:0] f, input logic [1:0] o,
                        input logic [2:0] s, input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] r, input logic [127:0] l);
      @(negedge clk);
      fmt = f; op = o; sub = s; rs1 = a; rs2 = b; res = r; load = l;
      model();
      #1 cmp(tag, 1'b0);
      @(posedge clk);
      #1 cmp(tag, 1'b1);   // R12: registered copy one clock later
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [127:0] rnd_box(input int kind);
      logic [127:0] v = rnd128();
      case (kind)
         0: v[127:32] = '1;
         1: v[127:64] = '1;
         2: begin v[127:64] = '1; v[40] = 1'b0; end
         3: begin v[127:32] = '1; v[100] = 1'b0; end
         default: ;
      endcase
      return v;
   endfunction

   localparam logic [127:0] QNAN_PAY = 128'h7FFF_8000_1234_5678_9ABC_DEF0_0000_0001;
   localparam logic [127:0] SBOX_POS = {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'h3F80_0000};
   localparam logic [127:0] SBOX_NEG = {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'hC040_0000};
   localparam logic [127:0] DBOX_POS = {64'hFFFFFFFF_FFFFFFFF, 64'h4000_0000_0000_0001};
   localparam logic [127:0] DBOX_NEG = {64'hFFFFFFFF_FFFFFFFF, 64'hBFF0_0000_0000_0000};

   task automatic summary;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      chk("R12", "reset wr_en",   {127'd0, r_we}, '0);
      chk("R12", "reset wr_val",  r_wv, '0);
      chk("R12", "reset opa",     r_oa, '0);
      chk("R12", "reset illegal", {127'd0, r_ill}, '0);
      @(negedge clk) rst_n = 1'b1;

      // R2 single boxing of result and load
      apply("R2", 2'b00, 2'b00, 3'd0, '0, '0, 128'h1234_5678_9ABC_DEF0_CAFE_F00D_4049_0FDB, '0);
      apply("R2", 2'b00, 2'b01, 3'd0, '0, '0, '0, 128'h0_0000_BEEF);
      // R3 double boxing
      apply("R3", 2'b01, 2'b00, 3'd0, '0, '0, 128'h0000_1111_2222_3333_4009_21FB_5444_2D18, '0);
      apply("R3", 2'b01, 2'b01, 3'd0, '0, '0, '0, rnd128());
      // R4 quad pass, NaN payload kept
      apply("R4", 2'b11, 2'b01, 3'd0, '0, '0, '0, QNAN_PAY);
      apply("R4", 2'b11, 2'b00, 3'd0, '0, '0, QNAN_PAY ^ 128'h1, '0);
      // R5 single unbox: proper, inner broken, outer broken, nothing boxed
      apply("R5", 2'b00, 2'b00, 3'd0, SBOX_POS, {64'hFFFFFFFF_FFFFFFFF, 64'h1234_0000_3F80_0000}, '0, '0);
      apply("R5", 2'b00, 2'b00, 3'd0, {1'b0, SBOX_POS[126:0]}, 128'h3F80_0000, '0, '0);
      // R6 double unbox: proper, top bit cleared, zero upper
      apply("R6", 2'b01, 2'b00, 3'd0, DBOX_POS, {1'b0, DBOX_POS[126:0]}, '0, '0);
      apply("R6", 2'b01, 2'b00, 3'd0, SBOX_POS, 128'h4000_0000_0000_0000, '0, '0);
      // R7 quad operands untouched
      apply("R7", 2'b11, 2'b00, 3'd0, QNAN_PAY, rnd128(), '0, '0);
      // R8 three sign variants at single
      apply("R8", 2'b00, 2'b10, 3'd0, SBOX_POS, SBOX_NEG, '0, '0);
      apply("R8", 2'b00, 2'b10, 3'd1, SBOX_POS, SBOX_NEG, '0, '0);
      apply("R8", 2'b00, 2'b10, 3'd2, SBOX_NEG, SBOX_NEG, '0, '0);
      apply("R8", 2'b01, 2'b10, 3'd1, DBOX_NEG, DBOX_POS, '0, '0);
      apply("R8", 2'b00, 2'b10, 3'd3, SBOX_POS, SBOX_NEG, '0, '0);
      apply("R8", 2'b01, 2'b10, 3'd7, DBOX_POS, DBOX_NEG, '0, '0);
      // R9 badly boxed sign source contributes canonical NaN sign (0)
      apply("R9", 2'b00, 2'b10, 3'd0, SBOX_NEG, 128'hC040_0000, '0, '0);
      apply("R9", 2'b01, 2'b10, 3'd2, 128'h8000_0000_0000_0000, DBOX_NEG, '0, '0);
      // R10 quad sign injection keeps the payload
      apply("R10", 2'b11, 2'b10, 3'd1, QNAN_PAY, 128'h0, '0, '0);
      apply("R10", 2'b11, 2'b10, 3'd2, {1'b1, QNAN_PAY[126:0]}, {1'b1, 127'd5}, '0, '0);
      // R1 half rejected
      apply("R1", 2'b10, 2'b00, 3'd0, SBOX_POS, DBOX_POS, rnd128(), '0);
      apply("R1", 2'b10, 2'b10, 3'd0, rnd128(), rnd128(), '0, '0);
      // R11 reserved op
      apply("R11", 2'b00, 2'b11, 3'd0, SBOX_POS, 128'h5, rnd128(), rnd128());
      apply("R11", 2'b11, 2'b11, 3'd0, QNAN_PAY, QNAN_PAY, '0, '0);

      // mixed patterns across every code
      for (int n = 0; n < 300; n++) begin
         apply("R12", 2'($urandom), 2'($urandom), 3'($urandom_range(0, 4)),
               rnd_box(int'($urandom_range(0, 4))), rnd_box(int'($urandom_range(0, 4))),
               rnd128(), rnd128());
      end

      summary();
      $finish;
   end
endmodule